// File: doc/BRIEF.md
# Weighted packet round-robin arbiter

This block shares one output path among four DMA channels. At any time it grants at most one channel. Once a channel is granted, it may send a programmed number of whole packets in a row. After that allowance is used up, the grant moves to the next eligible channel in cyclic ascending order. Each channel's allowance comes from a 5-bit weight, which the surrounding configuration logic supplies. A weight of zero takes the channel out of arbitration. With every weight at 1, the block performs plain packet-by-packet round robin.

The transfer bus is shared, so the arbiter sees only the granted channel's beats. A beat is one with `vld_i` high, and `eop_i` marks the last beat of a packet. A channel keeps `req_i` high while it has a packet to send. It may lower `req_i` in the same cycle as its last beat if nothing else is queued, and it keeps `req_i` high from the moment it is granted until it has sent at least one packet. The grant output is registered. It changes only in the cycle after a packet ends, or while the arbiter is idle.

Top module: `wrr_arb`

## Requirements
- R1: After reset no grant is asserted, `gnt_idx_o` is 0, and the first search starts at channel 0.
- R2: `gnt_o` is one-hot or zero. While a grant is asserted, `gnt_idx_o` gives the index of the granted channel; otherwise it is 0.
- R3: While a channel holds the grant, the grant changes only in the cycle after a beat with both `vld_i` and `eop_i` high. A beat without `eop_i`, or `eop_i` without `vld_i`, leaves the grant unchanged.
- R4: A channel that keeps requesting holds the grant for exactly as many packets as its weight. The grant then moves on at the end of the last of those packets.
- R5: The next channel is chosen by searching upward from the current (or last) owner plus one, with wrap-around. Channels that are not requesting, or that have weight 0, are skipped. The current owner is considered last, so a lone requester is granted again with a fresh allowance.
- R6: A channel whose weight is 0 is never granted, even when it is the only requester.
- R7: If the owner lowers `req_i` on the last beat of a packet before its allowance is used up, the grant moves on at that packet boundary. The remaining allowance is discarded, and the channel's next grant starts from its full weight.
- R8: The packet allowance is loaded from the weight input when a channel is granted. A weight change during a burst takes effect only at that channel's next grant.
- R9: When no eligible channel is requesting, no grant is asserted. The search position keeps its value, so the next search starts after the last owner.
- R10: Weight bits `weight_i[5c+4:5c]` belong to channel c. With every weight set to 1 and all channels requesting, the grant cycles 0, 1, 2, 3, 0 with one packet per grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Per-channel request, one bit per channel |
| weight_i | input | 20 | Packed per-channel packet weights, 5 bits each, channel 0 in the low bits |
| vld_i | input | 1 | A beat is transferred on the shared path this cycle |
| eop_i | input | 1 | The current beat is the last beat of its packet |
| gnt_o | output | 4 | One-hot grant, all zero when idle |
| gnt_idx_o | output | 2 | Index of the granted channel, 0 when idle |

## Verification
The bench first uses equal unit weights with every channel requesting, which shows whether the search order and its wrap-around are correct. It then applies unequal weights that include a zero. That pattern separates exact burst lengths from off-by-one counts and confirms that disabled channels are skipped. Further patterns cover multi-beat packets with stray `eop_i` and an owner that drops its request early. They also cover a weight changed in the middle of a burst, and a lone requester that either keeps requesting or goes quiet. Together these cover the boundary-only grant changes, discarding and reloading of the allowance, re-granting of the owner as the last candidate, and the idle state with the search position held.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  localparam int unsigned DEF_NCH = 4;
  localparam int unsigned DEF_WW  = 5;

  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wrr_pick.sv
// Cyclic first-eligible search starting after base_i; base_i itself is last.
module wrr_pick #(
  parameter int unsigned NCH = wrr_pkg::DEF_NCH,
  localparam int unsigned IW = wrr_pkg::idx_w(NCH)
) (
  input  logic [NCH-1:0] elig_i,
  input  logic [IW-1:0]  base_i,
  output logic           found_o,
  output logic [IW-1:0]  idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 1; i <= int'(NCH); i++) begin
      int c;
      c = (int'(base_i) + i) % int'(NCH);
      if (!found_o && elig_i[c]) begin
        found_o = 1'b1;
        idx_o   = IW'(c);
      end
    end
  end

  always_comb begin
    if (found_o) p_pick_elig_r5: assert (elig_i[idx_o]);
  end
endmodule

// File: rtl/wrr_credit.sv
// Remaining packet allowance of the current owner.
module wrr_credit #(
  parameter int unsigned WW = wrr_pkg::DEF_WW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [WW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          last_o
);
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q[WW-1:1] == '0);

  p_load_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> load_val_i != '0);
  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q > WW'(1));
endmodule

// File: rtl/wrr_arb.sv
module wrr_arb #(
  parameter int unsigned NCH = wrr_pkg::DEF_NCH,
  parameter int unsigned WW  = wrr_pkg::DEF_WW,
  localparam int unsigned IW = wrr_pkg::idx_w(NCH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCH-1:0]  req_i,
  input  logic [NCH*WW-1:0] weight_i,
  input  logic            vld_i,
  input  logic            eop_i,
  output logic [NCH-1:0]  gnt_o,
  output logic [IW-1:0]   gnt_idx_o
);
  logic [WW-1:0]  w [NCH];
  logic [NCH-1:0] elig;
  logic [IW-1:0]  owner_q, ptr_q, pick_idx;
  logic           own_vld_q, pick_found, cred_last;
  logic           pkt_end, stay, rearb, load;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign w[c]    = weight_i[c*WW +: WW];
    assign elig[c] = req_i[c] && (w[c] != '0);
  end

  assign pkt_end = own_vld_q && vld_i && eop_i;
  // keep the grant only with allowance left and another packet queued
  assign stay    = pkt_end && !cred_last && req_i[owner_q];
  assign rearb   = !own_vld_q || (pkt_end && !stay);
  assign load    = rearb && pick_found;

  wrr_pick #(.NCH(NCH)) u_pick (
    .elig_i (elig),
    .base_i (ptr_q),
    .found_o(pick_found),
    .idx_o  (pick_idx)
  );

  wrr_credit #(.WW(WW)) u_credit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(w[pick_idx]),
    .dec_i     (stay),
    .last_o    (cred_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q   <= '0;
      own_vld_q <= 1'b0;
      ptr_q     <= IW'(NCH-1);
    end else if (load) begin
      owner_q   <= pick_idx;
      own_vld_q <= 1'b1;
      ptr_q     <= pick_idx;
    end else if (rearb) begin
      own_vld_q <= 1'b0;
    end
  end

  always_comb begin
    gnt_o = '0;
    if (own_vld_q) gnt_o[owner_q] = 1'b1;
  end
  assign gnt_idx_o = own_vld_q ? owner_q : '0;

  p_gnt_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_hold_mid_pkt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_vld_q && !(vld_i && eop_i)) |=> $stable(gnt_o));
  p_idle_ptr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rearb && !pick_found) |=> (gnt_o == '0) && $stable(ptr_q));
  p_owner_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_end && !stay && pick_found && (elig & ~gnt_o) != '0) |=> !$stable(gnt_o));
endmodule

// File: tb/tb_wrr_arb.sv
`timescale 1ns/1ps
module tb_wrr_arb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  req_i = '0;
  logic [19:0] weight_i = '0;
  logic        vld_i = 1'b0;
  logic        eop_i = 1'b0;
  logic [3:0]  gnt_o;
  logic [1:0]  gnt_idx_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  wrr_arb dut (.*);

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input logic [3:0] exp, input string tag);
    logic [1:0] ei = '0;
    for (int i = 0; i < 4; i++) if (exp[i]) ei = 2'(i);
    n_chk++;
    if (gnt_o !== exp || gnt_idx_o !== ei) begin
      n_fail++;
      $display("FAIL %s: gnt=%b idx=%0d expected gnt=%b idx=%0d", tag, gnt_o, gnt_idx_o, exp, ei);
    end
  endtask

  task automatic set_w(input logic [4:0] w0, w1, w2, w3);
    weight_i = {w3, w2, w1, w0};
  endtask

  task automatic do_reset();
    vld_i = 0; eop_i = 0; req_i = '0;
    rst_ni = 0; #7; rst_ni = 1; step();
  endtask

  task automatic pkt(input int beats, input logic [3:0] req_at_eop);
    for (int b = 0; b < beats - 1; b++) begin vld_i = 1; eop_i = 0; step(); end
    vld_i = 1; eop_i = 1; req_i = req_at_eop; step();
    vld_i = 0; eop_i = 0;
  endtask

  task automatic t_reset();
    set_w(1, 1, 1, 1);
    do_reset();
    chk(4'b0000, "R1 idle after reset");
  endtask

  task automatic t_plain_rr();
    do_reset(); set_w(1, 1, 1, 1); req_i = 4'hF; step();
    chk(4'b0001, "R1 first grant is ch0");
    pkt(1, 4'hF); chk(4'b0010, "R10 rr to ch1");
    pkt(1, 4'hF); chk(4'b0100, "R10 rr to ch2");
    pkt(1, 4'hF); chk(4'b1000, "R10 rr to ch3");
    pkt(1, 4'hF); chk(4'b0001, "R10 R2 wrap to ch0");
  endtask

  task automatic t_weights();
    do_reset(); set_w(3, 2, 0, 1); req_i = 4'hF; step();
    chk(4'b0001, "R4 start ch0");
    pkt(1, 4'hF); chk(4'b0001, "R4 ch0 pkt1 keeps");
    pkt(1, 4'hF); chk(4'b0001, "R4 ch0 pkt2 keeps");
    pkt(1, 4'hF); chk(4'b0010, "R4 ch0 moves after 3");
    pkt(1, 4'hF); chk(4'b0010, "R4 ch1 keeps");
    pkt(1, 4'hF); chk(4'b1000, "R6 R5 zero-weight ch2 skipped");
    pkt(1, 4'hF); chk(4'b0001, "R5 wrap to ch0");
  endtask

  task automatic t_mid_pkt();
    do_reset(); set_w(1, 1, 1, 1); req_i = 4'b0011; step();
    chk(4'b0001, "R3 start ch0");
    vld_i = 1; eop_i = 0; step(); chk(4'b0001, "R3 beat 1 holds");
    step(); chk(4'b0001, "R3 beat 2 holds");
    vld_i = 0; eop_i = 1; step(); chk(4'b0001, "R3 eop without vld holds");
    vld_i = 1; eop_i = 1; step(); vld_i = 0; eop_i = 0;
    chk(4'b0010, "R3 change after eop");
  endtask

  task automatic t_early_drop();
    do_reset(); set_w(4, 1, 1, 1); req_i = 4'b0011; step();
    chk(4'b0001, "R7 start ch0");
    pkt(1, 4'b0010); chk(4'b0010, "R7 early drop moves on");
    pkt(1, 4'b0011); chk(4'b0001, "R7 back to ch0");
    pkt(1, 4'b0011); chk(4'b0001, "R7 fresh count 1");
    pkt(1, 4'b0011); chk(4'b0001, "R7 fresh count 2");
    pkt(1, 4'b0011); chk(4'b0001, "R7 fresh count 3");
    pkt(1, 4'b0011); chk(4'b0010, "R7 full weight 4 used");
  endtask

  task automatic t_wchange();
    do_reset(); set_w(2, 1, 1, 1); req_i = 4'b0011; step();
    chk(4'b0001, "R8 start ch0");
    set_w(3, 1, 1, 1);
    pkt(1, 4'b0011); chk(4'b0001, "R8 old weight keeps");
    pkt(1, 4'b0011); chk(4'b0010, "R8 old weight 2 used");
    pkt(1, 4'b0011); chk(4'b0001, "R8 regrant ch0");
    pkt(1, 4'b0011); pkt(1, 4'b0011);
    chk(4'b0001, "R8 new weight keeps");
    pkt(1, 4'b0011); chk(4'b0010, "R8 new weight 3 used");
  endtask

  task automatic t_idle();
    do_reset(); set_w(1, 1, 1, 1); req_i = 4'b0100; step();
    chk(4'b0100, "R9 lone ch2");
    pkt(1, 4'b0100); chk(4'b0100, "R5 lone owner regranted");
    pkt(1, 4'b0000); chk(4'b0000, "R9 no requester idle");
    step(); step(); chk(4'b0000, "R9 stays idle");
    req_i = 4'hF; step();
    chk(4'b1000, "R9 search resumes after ch2");
    do_reset(); set_w(1, 0, 1, 1); req_i = 4'b0010; step(); step();
    chk(4'b0000, "R6 lone zero-weight never granted");
  endtask

  initial begin
    t_reset();
    t_plain_rr();
    t_weights();
    t_mid_pkt();
    t_early_drop();
    t_wchange();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule